// File: doc/BRIEF.md
# SPI Master Channel with Split Clock Divider

This block is one SPI master channel. A host loads a word into a transmit holding register. The channel then shifts that word out on `mosi`, most significant bit first, and samples `miso` into a receive register. Each word is 8, 16 or 32 bits long. The serial clock comes from the module clock through a 12-bit divide count. That count is assembled from a 4-bit low field and an 8-bit extension field, so the step is one module clock.

Clock polarity and phase are set by a 2-bit sub-mode, and the chip-select active level is set by its own bit. Without software control, chip select is active for the length of one word and inactive between words. A force bit holds chip select active across any number of consecutive words. Two flags drive the host-side handshake: `tx_ready` shows that the transmit register can take a word, and `rx_valid` shows that a received word is waiting to be read. No shifting takes place while the channel enable bit is low.

Top module: `spi_master_chan`

## Requirements
- R1: While reset is asserted and straight after it, `tx_ready` is 1, `rx_valid` and `rx_overrun` are 0, chip select is at its inactive level and `sclk` rests at the idle level of the selected sub-mode.
- R2: Each serial clock half-period lasts D+1 module clocks, where D = {`cfg_div_ext`, `cfg_div_lo`} (extension field in bits 11:4, low field in bits 3:0).
- R3: `cfg_mode` is {polarity, phase}. Polarity is the idle level of `sclk`. With phase 0, `miso` is sampled on the first edge of each bit and `mosi` changes on the second edge. With phase 1, `mosi` changes on the first edge and `miso` is sampled on the second. A word of N bits produces exactly 2N edges.
- R4: `cfg_wlen` gives 8 bits for code 0, 16 bits for code 1 and 32 bits for codes 2 and 3. Only the low N bits of `tx_data` are sent, MSB first. The received word appears in the low N bits of `rx_data`, with zeros above.
- R5: `cfg_cs_high` = 1 makes chip select active-high. `cfg_cs_high` = 0 makes it active-low.
- R6: When `cs_force` is 0, chip select is active for each word and returns to inactive after the word, so each word produces one deassertion.
- R7: When `cs_force` is 1, chip select is active at once, even with no word in flight, and it stays active across consecutive words. Clearing the bit returns chip select to inactive when no word is in flight.
- R8: A write (`tx_wr`) accepted while `tx_ready` is 1 clears `tx_ready` on the next cycle. A write while `tx_ready` is 0 is ignored, and the word held earlier is the one sent.
- R9: `rx_valid` rises when a word completes and stays high until `rx_rd` is pulsed. A read clears it on the next cycle.
- R10: If a word completes while `rx_valid` is 1 and no read is given in that cycle, the new word replaces the old one and `rx_overrun` is set. `rx_overrun` stays set until the next `rx_rd`.
- R11: While `chan_en` is 0, `sclk` does not toggle and no word is started. A word already written waits in the transmit register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; shifting happens only while high |
| cfg_mode | input | 2 | Sub-mode {polarity, phase} |
| cfg_wlen | input | 2 | Word length code (0: 8, 1: 16, 2/3: 32) |
| cfg_cs_high | input | 1 | Chip-select active level, 1 = active-high |
| cfg_div_lo | input | 4 | Divide count bits 3:0 |
| cfg_div_ext | input | 8 | Divide count bits 11:4 |
| cs_force | input | 1 | Hold chip select active |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | 32 | Word to transmit |
| tx_ready | output | 1 | Transmit register can accept a word |
| rx_rd | input | 1 | Read strobe, consumes the received word |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | Received word waiting |
| rx_overrun | output | 1 | Sticky flag: an unread word was overwritten |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip select |

## Verification
The hardest state to reach is chip select held active across a word boundary while the transmit register refills. The second write has to land during the first word, and the bench has to see that chip select never dropped between the two words. The bench gets there by setting the force bit before the first write, then polling `tx_ready` and writing again as soon as the first word moves into the shifter. A slave model in the bench counts chip-select deassertions and collects the 16 `mosi` bits of both words. The overrun case is reached the same way: a second word is allowed to finish before the first one is read.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_DONE  = 2'd2
  } eng_state_e;

  // Word length code to bit count; codes 2 and 3 both select 32 bits.
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div);
  assign tick   = run && at_end;

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBW    = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              tick,
  input  logic [1:0]        mode,
  input  logic [NBW-1:0]    nbits,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_buf,
  input  logic              miso,
  output logic              load,
  output logic              run,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_act,
  output logic              push,
  output logic [DATA_W-1:0] push_word
);

  localparam int EW = NBW + 1;
  localparam logic [NBW-1:0] FULL_W = NBW'(DATA_W);

  eng_state_e        state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rsh_q, rsh_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic              lvl_q, lvl_d;
  logic [EW-1:0]     edge_end;
  logic [NBW-1:0]    shamt;
  logic              cpol, cpha, lead, sample_now;

  assign cpol       = mode[1];
  assign cpha       = mode[0];
  assign edge_end   = {nbits, 1'b0};
  assign shamt      = FULL_W - nbits;
  assign lead       = ~edge_q[0];
  assign sample_now = lead ^ cpha;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    rsh_d   = rsh_q;
    edge_d  = edge_q;
    lvl_d   = lvl_q;
    load    = 1'b0;
    push    = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (chan_en && tx_full) begin
          load    = 1'b1;
          sh_d    = tx_buf << shamt;
          rsh_d   = '0;
          edge_d  = '0;
          lvl_d   = 1'b0;
          state_d = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          if (edge_q == edge_end) begin
            state_d = ENG_DONE;
          end else begin
            lvl_d  = ~lvl_q;
            edge_d = edge_q + 1'b1;
            if (sample_now)        rsh_d = {rsh_q[DATA_W-2:0], miso};
            else if (edge_q != '0) sh_d  = sh_q << 1;
          end
        end
      end
      ENG_DONE: begin
        push    = 1'b1;
        state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sh_q    <= '0;
      rsh_q   <= '0;
      edge_q  <= '0;
      lvl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      rsh_q   <= rsh_d;
      edge_q  <= edge_d;
      lvl_q   <= lvl_d;
    end
  end

  assign run       = (state_q == ENG_SHIFT) && chan_en;
  assign sclk      = lvl_q ^ cpol;
  assign mosi      = sh_q[DATA_W-1];
  assign cs_act    = (state_q != ENG_IDLE);
  assign push_word = rsh_q;

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_word,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_overrun
);

  logic              valid_q, valid_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    valid_d = push | (valid_q & ~rd);
    ovr_d   = (push & valid_q & ~rd) | (ovr_q & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
      if (push) data_q <= push_word;
    end
  end

  assign rx_data    = data_q;
  assign rx_valid   = valid_q;
  assign rx_overrun = ovr_q;

endmodule

// File: rtl/spi_master_chan.sv
module spi_master_chan
  import spi_chan_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_LO_W  = 4,
  parameter int DIV_EXT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_en,
  input  logic [1:0]           cfg_mode,
  input  logic [1:0]           cfg_wlen,
  input  logic                 cfg_cs_high,
  input  logic [DIV_LO_W-1:0]  cfg_div_lo,
  input  logic [DIV_EXT_W-1:0] cfg_div_ext,
  input  logic                 cs_force,
  input  logic                 tx_wr,
  input  logic [DATA_W-1:0]    tx_data,
  output logic                 tx_ready,
  input  logic                 rx_rd,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 rx_valid,
  output logic                 rx_overrun,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 cs_out
);

  localparam int DIV_W = DIV_LO_W + DIV_EXT_W;
  localparam int NBW   = $clog2(DATA_W) + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // Transmit holding register.
  logic              tx_full_q, tx_full_d;
  logic [DATA_W-1:0] tx_buf_q;
  logic              accept, load;

  assign accept = tx_wr && !tx_full_q;

  always_comb tx_full_d = accept | (tx_full_q & ~load);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) tx_full_q <= 1'b0;
    else          tx_full_q <= tx_full_d;
  end

  always_ff @(posedge clk) begin
    if (accept) tx_buf_q <= tx_data;
  end

  assign tx_ready = ~tx_full_q;

  // Serial clock divider.
  logic [DIV_W-1:0] div_full;
  logic             run, tick;

  assign div_full = {cfg_div_ext, cfg_div_lo};

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_q_n),
    .run   (run),
    .div   (div_full),
    .tick  (tick)
  );

  // Shift engine.
  logic [NBW-1:0]    nbits;
  logic              cs_act, push;
  logic [DATA_W-1:0] push_word;

  assign nbits = NBW'(wlen_bits(cfg_wlen));

  spi_shift_eng #(.DATA_W(DATA_W), .NBW(NBW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .chan_en   (chan_en),
    .tick      (tick),
    .mode      (cfg_mode),
    .nbits     (nbits),
    .tx_full   (tx_full_q),
    .tx_buf    (tx_buf_q),
    .miso      (miso),
    .load      (load),
    .run       (run),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_act    (cs_act),
    .push      (push),
    .push_word (push_word)
  );

  // Receive register and flags.
  spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .push       (push),
    .push_word  (push_word),
    .rd         (rx_rd),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
  );

  // Chip select with programmable level.
  logic cs_on;
  assign cs_on  = cs_act | cs_force;
  assign cs_out = cfg_cs_high ? cs_on : ~cs_on;

endmodule

// File: rtl/spi_master_chan_chk.sv
module spi_master_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic [1:0] cfg_mode,
  input logic       cfg_cs_high,
  input logic       cs_force,
  input logic       tx_wr,
  input logic       tx_ready,
  input logic       rx_rd,
  input logic       rx_valid,
  input logic       rx_overrun,
  input logic       sclk,
  input logic       cs_out
);

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_ready) |=> !tx_ready);

  assert_idle_clock_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_out != cfg_cs_high) |-> (sclk == cfg_mode[1]));

  assert_force_keeps_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_force |-> (cs_out == cfg_cs_high));

  assert_no_toggle_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(chan_en) && $stable(cfg_mode)) |-> $stable(sclk));

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> ($past(rx_valid) && !$past(rx_rd)));

  assert_read_clears_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_valid) |=> !rx_overrun);

  assert_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rd) |=> rx_valid);

endmodule

bind spi_master_chan spi_master_chan_chk u_chk (.rst_n(rst_q_n), .*);

// File: tb/spi_master_chan_test.sv
module spi_master_chan_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chan_en;
  logic [1:0]  cfg_mode;
  logic [1:0]  cfg_wlen;
  logic        cfg_cs_high;
  logic [3:0]  cfg_div_lo;
  logic [7:0]  cfg_div_ext;
  logic        cs_force;
  logic        tx_wr;
  logic [31:0] tx_data;
  logic        tx_ready;
  logic        rx_rd;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic        rx_overrun;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic        cs_out;

  always #2 clk = ~clk;

  spi_master_chan uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_mode(cfg_mode),
    .cfg_wlen(cfg_wlen), .cfg_cs_high(cfg_cs_high), .cfg_div_lo(cfg_div_lo),
    .cfg_div_ext(cfg_div_ext), .cs_force(cs_force), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_overrun(rx_overrun), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_out(cs_out)
  );

  int tests = 0;
  int fails = 0;

  // Slave model state (configured by the bench alongside the DUT).
  logic        cur_cs_high = 1'b0;
  logic        cur_cpol = 1'b0;
  logic        cur_cpha = 1'b0;
  int          cur_nb = 8;
  logic [31:0] s_word = 32'h0;
  logic [31:0] slave_got = 32'h0;
  int          bitpos = 0;
  int          edges = 0;
  int          cs_drops = 0;
  int          cyc = 0;
  int          last_edge = 0;
  int          gap = 0;
  logic        cs_prev = 1'b0;
  logic        sclk_prev = 1'b0;
  logic        cs_on;

  always @(posedge clk) begin
    #1;
    cyc++;
    cs_on = (cs_out == cur_cs_high);
    if (cs_on && !cs_prev) begin
      bitpos = cur_nb - 1;
      if (!cur_cpha) miso = s_word[bitpos];
    end
    if (!cs_on && cs_prev) cs_drops++;
    if (sclk !== sclk_prev) begin
      edges++;
      gap = cyc - last_edge;
      last_edge = cyc;
      if (cs_on) begin
        if (sclk != cur_cpol) begin
          if (!cur_cpha) slave_got = {slave_got[30:0], mosi};
          else begin
            if (bitpos >= 0) miso = s_word[bitpos];
            bitpos--;
          end
        end else begin
          if (!cur_cpha) begin
            bitpos--;
            if (bitpos >= 0) miso = s_word[bitpos];
          end else slave_got = {slave_got[30:0], mosi};
        end
      end
    end
    cs_prev = cs_on;
    sclk_prev = sclk;
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  wl;
    logic        csh;
    logic [11:0] div;
    logic [31:0] tx;
    logic [31:0] sl;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{2'd0, 2'd0, 1'b0, 12'h001, 32'hFFFF_FFA5, 32'h0000_003C},
    '{2'd1, 2'd1, 1'b1, 12'h000, 32'h5555_1234, 32'h0000_BEEF},
    '{2'd2, 2'd2, 1'b0, 12'h002, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
    '{2'd3, 2'd0, 1'b1, 12'h013, 32'h0000_0081, 32'h0000_007E},
    '{2'd1, 2'd2, 1'b0, 12'h001, 32'h8000_0001, 32'hC0FF_EE11},
    '{2'd2, 2'd1, 1'b1, 12'h0F0, 32'h0000_8001, 32'h0000_7FFE},
    '{2'd0, 2'd3, 1'b0, 12'h000, 32'h1357_9BDF, 32'h2468_ACE0}
  };

  function automatic int nb_of(input logic [1:0] wl);
    if (wl == 2'd0) return 8;
    if (wl == 2'd1) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] mask_of(input int nb);
    if (nb == 32) return 32'hFFFF_FFFF;
    return (32'd1 << nb) - 32'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] mode, input logic [1:0] wl, input logic csh,
                       input logic [11:0] div);
    @(negedge clk);
    cfg_mode = mode; cfg_wlen = wl; cfg_cs_high = csh;
    cfg_div_lo = div[3:0]; cfg_div_ext = div[11:4];
    cur_cpol = mode[1]; cur_cpha = mode[0]; cur_cs_high = csh; cur_nb = nb_of(wl);
    repeat (3) @(negedge clk);
    edges = 0; cs_drops = 0; slave_got = 32'h0;
  endtask

  task automatic write_tx(input logic [31:0] w);
    tx_wr = 1'b1; tx_data = w;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic wait_rx(input string req);
    int n = 0;
    while (!rx_valid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, rx_valid}, 32'd1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b1; cfg_mode = 2'd0; cfg_wlen = 2'd0; cfg_cs_high = 1'b0;
    cfg_div_lo = 4'd1; cfg_div_ext = 8'd0; cs_force = 1'b0; tx_wr = 1'b0;
    tx_data = 32'h0; rx_rd = 1'b0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk("R1 tx_ready in reset", {31'b0, tx_ready}, 32'd1);
    chk("R1 rx_valid in reset", {31'b0, rx_valid}, 32'd0);
    chk("R1 rx_overrun in reset", {31'b0, rx_overrun}, 32'd0);
    chk("R1 cs inactive in reset", {31'b0, cs_out}, 32'd1);
    chk("R1 sclk idle in reset", {31'b0, sclk}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tx_ready after reset", {31'b0, tx_ready}, 32'd1);
    chk("R1 cs inactive after reset", {31'b0, cs_out}, 32'd1);

    // Vector table: modes, lengths, levels, divides.
    for (int i = 0; i < NV; i++) begin
      int nb;
      logic [31:0] m;
      nb = nb_of(VT[i].wl);
      m = mask_of(nb);
      s_word = VT[i].sl;
      setup(VT[i].mode, VT[i].wl, VT[i].csh, VT[i].div);
      chk("R5 cs inactive level", {31'b0, cs_out}, {31'b0, ~VT[i].csh});
      write_tx(VT[i].tx);
      wait_rx("R9 rx_valid after word");
      chk("R4 rx word MSB first", rx_data, VT[i].sl & m);
      chk("R4 mosi word MSB first", slave_got & m, VT[i].tx & m);
      chk("R3 edge count", edges, 2 * nb);
      chk("R2 half period", gap, {20'b0, VT[i].div} + 32'd1);
      chk("R6 one cs release per word", cs_drops, 32'd1);
      chk("R3 sclk idle after word", {31'b0, sclk}, {31'b0, VT[i].mode[1]});
      read_rx();
      chk("R9 read consumes", {31'b0, rx_valid}, 32'd0);
    end

    // R11 / R8: disabled channel, ignored write.
    s_word = 32'h0000_00F0;
    setup(2'd0, 2'd0, 1'b0, 12'h001);
    chan_en = 1'b0;
    @(negedge clk);
    write_tx(32'h11);
    chk("R8 tx_ready clears", {31'b0, tx_ready}, 32'd0);
    write_tx(32'h22);
    repeat (40) @(negedge clk);
    chk("R11 no sclk edges disabled", edges, 32'd0);
    chk("R11 cs idle disabled", {31'b0, cs_out}, 32'd1);
    chk("R11 word still waiting", {31'b0, tx_ready}, 32'd0);
    chan_en = 1'b1;
    wait_rx("R11 word after enable");
    chk("R8 ignored write not sent", slave_got[7:0], 32'h11);
    chk("R11 received word", rx_data, 32'hF0);
    read_rx();

    // R10: overrun.
    s_word = 32'h0000_0011;
    setup(2'd0, 2'd0, 1'b0, 12'h001);
    write_tx(32'h01);
    wait_rx("R10 first word");
    s_word = 32'h0000_0022;
    write_tx(32'h02);
    begin
      int n = 0;
      while (cs_drops < 2 && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    repeat (2) @(negedge clk);
    chk("R10 overrun set", {31'b0, rx_overrun}, 32'd1);
    chk("R10 newest word kept", rx_data, 32'h22);
    read_rx();
    chk("R9 read clears valid", {31'b0, rx_valid}, 32'd0);
    chk("R10 read clears overrun", {31'b0, rx_overrun}, 32'd0);

    // R7: forced chip select across words.
    setup(2'd0, 2'd0, 1'b0, 12'h001);
    cs_force = 1'b1;
    @(negedge clk);
    chk("R7 forced cs while idle", {31'b0, cs_out}, 32'd0);
    edges = 0; cs_drops = 0; slave_got = 32'h0;
    write_tx(32'hC3);
    begin
      int n = 0;
      while (!tx_ready && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    write_tx(32'h5A);
    wait_rx("R7 first forced word");
    read_rx();
    wait_rx("R7 second forced word");
    read_rx();
    repeat (4) @(negedge clk);
    chk("R7 cs held across words", cs_drops, 32'd0);
    chk("R7 both words sent", slave_got[15:0], 32'hC35A);
    chk("R7 edge count two words", edges, 32'd32);
    cs_force = 1'b0;
    @(negedge clk);
    chk("R7 cs released", {31'b0, cs_out}, 32'd1);

    summary();
    $finish;
  end

endmodule